// File: doc/BRIEF.md
# Stack Frame Sequencer

This block runs the memory side of subroutine linkage for a small 32-bit core. The decoder hands it one stack command with the operand values it needs. The block then issues the word reads and writes in a fixed order over a single-outstanding request/acknowledge port. It writes the new stack pointer, frame pointer and other register values back one at a time through a register write port, and it writes the new program counter through a separate port.

Register 0 serves as the frame pointer and register 1 as the stack pointer.

A call builds a three-word frame on the stack: the return address, an unused static-chain word beside it, and the saved frame pointer. A return tears that frame down in the reverse order. Push and pop move one word through any register used as a stack pointer.

The block holds `busy` high while a command is in progress and marks the end of each command with a one-cycle `done`.

Top module: `frame_seq`

## Requirements
- R1: A call (cmd_op 0 absolute, 1 register) writes register 1 with SP-8 and stores the return address at SP-8. It then writes register 1 with SP-12 and stores the old FP at SP-12. It then writes register 0 with SP-12, and finally writes the PC with the target. The two stores occur in that order.
- R2: The stored return address is cmd_pc+6 for the absolute call (target taken from cmd_tgt) and cmd_pc+2 for the register call.
- R3: The register call jumps to the value of register opa_idx. When that index is 0 or 1, the target is the updated SP (SP-12) instead.
- R4: A return (cmd_op 2) writes register 1 with FP and reads FP into register 0 from address FP. It then writes register 1 with FP+4, reads the PC from address FP+4, and writes register 1 with FP+12.
- R5: A push (cmd_op 3) writes register opa_idx with its value minus 4 and stores register opb_idx at that address. When the two indices are equal, the stored word is the decremented value.
- R6: A pop (cmd_op 4) reads from the address in register opa_idx into register opb_idx, then writes register opa_idx with its old value plus 4. When the two indices are equal, register opa_idx ends as the loaded word plus 4.
- R7: Every transfer is a 32-bit word. A request keeps its address, direction and data stable until acknowledged, and the sequencer does not advance past a transfer before its acknowledge.
- R8: `busy` is high from the cycle after acceptance until the done cycle. A command presented while busy, or with cmd_op 5 to 7, is ignored and causes no register write.
- R9: `done` is a one-cycle pulse with `busy` low. `pc_we` is asserted only in the done cycle of a call or return.
- R10: After reset `busy`, `done`, `mem_req`, `rf_we` and `pc_we` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 3 | Command code (0 call absolute, 1 call register, 2 return, 3 push, 4 pop) |
| cmd_pc | input | DW | Address of the command |
| cmd_tgt | input | DW | Absolute call target |
| fp_val | input | DW | Current value of register 0 |
| sp_val | input | DW | Current value of register 1 |
| opa_idx | input | RW | Stack / target register index |
| opb_idx | input | RW | Value / destination register index |
| opa_val | input | DW | Value of register opa_idx |
| opb_val | input | DW | Value of register opb_idx |
| busy | output | 1 | Command in progress |
| done | output | 1 | Command finished (one cycle) |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | DW | Byte address of the word |
| mem_wdata | output | DW | Write data |
| mem_ack | input | 1 | Request accepted / read data valid |
| mem_rdata | input | DW | Read data |
| rf_we | output | 1 | Register write enable |
| rf_waddr | output | RW | Register write index |
| rf_wdata | output | DW | Register write data |
| pc_we | output | 1 | Program counter write enable |
| pc_wdata | output | DW | New program counter |

## Verification
Assertions check several behaviours on every cycle:
- that a pending request holds steady and the controller stalls until the acknowledge,
- that `done` lasts one cycle with `busy` low,
- that the PC is only written in a done cycle,
- that a request never appears while idle.

The frame arithmetic can only be shown by the bench's scenarios, which track a register file and memory through nested calls and returns. These scenarios cover the return address offsets, the target substitution when the call register is the stack or frame pointer, and the equal-index push and pop cases. The same holds for the ignoring of commands while busy or with unknown codes.

// File: rtl/fs_pkg.sv
package fs_pkg;

   typedef enum logic [2:0] {
      CMD_CALL_ABS = 3'd0,
      CMD_CALL_REG = 3'd1,
      CMD_RETURN   = 3'd2,
      CMD_PUSH     = 3'd3,
      CMD_POP      = 3'd4
   } fs_cmd_e;

   localparam logic [2:0] CMD_LAST = 3'd4;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_CALL_RA,
      ST_CALL_FP,
      ST_RET_FP,
      ST_RET_SP,
      ST_RET_PC,
      ST_PUSH_W,
      ST_POP_R,
      ST_POP_INC,
      ST_FIN
   } fs_state_e;

endpackage

// File: rtl/fs_offset.sv
// Word-step offsets around a stack address.
module fs_offset #(
   parameter int DW = 32,
   parameter int WB = 4
) (
   input  logic [DW-1:0] base,
   output logic [DW-1:0] dn1,
   output logic [DW-1:0] dn2,
   output logic [DW-1:0] up1,
   output logic [DW-1:0] up2
);
   localparam logic [DW-1:0] STEP  = DW'(WB);
   localparam logic [DW-1:0] STEP2 = DW'(2 * WB);

   assign dn1 = base - STEP;
   assign dn2 = base - STEP2;
   assign up1 = base + STEP;
   assign up2 = base + STEP2;
endmodule

// File: rtl/fs_mem_port.sv
// Holds one memory request until it is acknowledged.
module fs_mem_port #(
   parameter int DW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          issue,
   input  logic          issue_we,
   input  logic [DW-1:0] issue_addr,
   input  logic [DW-1:0] issue_data,
   input  logic          ack,
   output logic          req,
   output logic          we,
   output logic [DW-1:0] addr,
   output logic [DW-1:0] wdata
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req   <= 1'b0;
         we    <= 1'b0;
         addr  <= '0;
         wdata <= '0;
      end else if (issue) begin
         req   <= 1'b1;
         we    <= issue_we;
         addr  <= issue_addr;
         wdata <= issue_data;
      end else if (ack) begin
         req <= 1'b0;
      end
   end

   // R7: an unanswered request keeps its contents
   a_r7_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
      req && !ack |=> req && $stable(addr) && $stable(we) && $stable(wdata));
endmodule

// File: rtl/frame_seq.sv
module frame_seq
   import fs_pkg::*;
#(
   parameter int DW           = 32,
   parameter int RW           = 4,
   parameter int FP_IDX       = 0,
   parameter int SP_IDX       = 1,
   parameter int ABS_CALL_LEN = 6,
   parameter int REG_CALL_LEN = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cmd_valid,
   input  logic [2:0]    cmd_op,
   input  logic [DW-1:0] cmd_pc,
   input  logic [DW-1:0] cmd_tgt,
   input  logic [DW-1:0] fp_val,
   input  logic [DW-1:0] sp_val,
   input  logic [RW-1:0] opa_idx,
   input  logic [RW-1:0] opb_idx,
   input  logic [DW-1:0] opa_val,
   input  logic [DW-1:0] opb_val,
   output logic          busy,
   output logic          done,
   output logic          mem_req,
   output logic          mem_we,
   output logic [DW-1:0] mem_addr,
   output logic [DW-1:0] mem_wdata,
   input  logic          mem_ack,
   input  logic [DW-1:0] mem_rdata,
   output logic          rf_we,
   output logic [RW-1:0] rf_waddr,
   output logic [DW-1:0] rf_wdata,
   output logic          pc_we,
   output logic [DW-1:0] pc_wdata
);
   localparam int            WB  = DW / 8;
   localparam logic [RW-1:0] FPR = RW'(FP_IDX);
   localparam logic [RW-1:0] SPR = RW'(SP_IDX);

   generate
      if (DW % 8 != 0 || DW < 16) begin : g_bad_dw
         $error("frame_seq: DW must be a multiple of 8 and at least 16");
      end
      if (FP_IDX == SP_IDX || FP_IDX >= (1 << RW) || SP_IDX >= (1 << RW)) begin : g_bad_idx
         $error("frame_seq: frame and stack register indices must differ and fit RW");
      end
   endgenerate

   fs_state_e     state;
   logic [DW-1:0] wsp, wfp, tgt;
   logic [RW-1:0] a_q, b_q;
   logic          pc_pend, use_new_sp;

   fs_cmd_e op;
   logic    op_known, accept, is_call, same_ab, waiting;
   assign op       = fs_cmd_e'(cmd_op);
   assign op_known = cmd_op <= CMD_LAST;
   assign accept   = cmd_valid && (state == ST_IDLE) && op_known;
   assign is_call  = (op == CMD_CALL_ABS) || (op == CMD_CALL_REG);
   assign same_ab  = (opa_idx == opb_idx);
   assign waiting  = (state == ST_CALL_RA) || (state == ST_CALL_FP) || (state == ST_RET_FP) ||
                     (state == ST_RET_PC) || (state == ST_PUSH_W) || (state == ST_POP_R);

   logic [DW-1:0] ret_addr;
   assign ret_addr = cmd_pc + ((op == CMD_CALL_ABS) ? DW'(ABS_CALL_LEN) : DW'(REG_CALL_LEN));

   // offset units: [0] on the command's stack operand, [1] on the working SP
   logic [DW-1:0] base [2];
   logic [DW-1:0] dn1 [2];
   logic [DW-1:0] dn2 [2];
   logic [DW-1:0] up1 [2];
   logic [DW-1:0] up2 [2];
   assign base[0] = is_call ? sp_val : opa_val;
   assign base[1] = wsp;

   generate
      for (genvar gi = 0; gi < 2; gi++) begin : g_off
         fs_offset #(.DW(DW), .WB(WB)) u_off (
            .base(base[gi]), .dn1(dn1[gi]), .dn2(dn2[gi]), .up1(up1[gi]), .up2(up2[gi]));
      end
   endgenerate

   // memory issue decisions
   logic          iss, iss_we;
   logic [DW-1:0] iss_addr, iss_data;

   always_comb begin
      iss      = 1'b0;
      iss_we   = 1'b0;
      iss_addr = '0;
      iss_data = '0;
      case (state)
         ST_IDLE: if (accept) begin
            iss = 1'b1;
            case (op)
               CMD_CALL_ABS, CMD_CALL_REG: begin
                  iss_we = 1'b1; iss_addr = dn2[0]; iss_data = ret_addr;
               end
               CMD_RETURN: iss_addr = fp_val;
               CMD_PUSH: begin
                  iss_we = 1'b1; iss_addr = dn1[0];
                  iss_data = same_ab ? dn1[0] : opb_val;
               end
               default: iss_addr = opa_val;
            endcase
         end
         ST_CALL_RA: if (mem_ack) begin
            iss = 1'b1; iss_we = 1'b1; iss_addr = dn1[1]; iss_data = wfp;
         end
         ST_RET_SP: begin
            iss = 1'b1; iss_addr = up1[1];
         end
         default: ;
      endcase
   end

   fs_mem_port #(.DW(DW)) u_port (
      .clk(clk), .rst_n(rst_n), .issue(iss), .issue_we(iss_we), .issue_addr(iss_addr),
      .issue_data(iss_data), .ack(mem_ack), .req(mem_req), .we(mem_we), .addr(mem_addr),
      .wdata(mem_wdata));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= ST_IDLE;
         wsp        <= '0;
         wfp        <= '0;
         tgt        <= '0;
         a_q        <= '0;
         b_q        <= '0;
         pc_pend    <= 1'b0;
         use_new_sp <= 1'b0;
         busy       <= 1'b0;
         done       <= 1'b0;
         rf_we      <= 1'b0;
         rf_waddr   <= '0;
         rf_wdata   <= '0;
         pc_we      <= 1'b0;
         pc_wdata   <= '0;
      end else begin
         rf_we <= 1'b0;
         done  <= 1'b0;
         pc_we <= 1'b0;
         case (state)
            ST_IDLE: if (accept) begin
               busy <= 1'b1;
               a_q  <= opa_idx;
               b_q  <= opb_idx;
               case (op)
                  CMD_CALL_ABS, CMD_CALL_REG: begin
                     wsp        <= dn2[0];
                     wfp        <= fp_val;
                     tgt        <= (op == CMD_CALL_ABS) ? cmd_tgt : opa_val;
                     use_new_sp <= (op == CMD_CALL_REG) && (opa_idx == FPR || opa_idx == SPR);
                     rf_we <= 1'b1; rf_waddr <= SPR; rf_wdata <= dn2[0];
                     state <= ST_CALL_RA;
                  end
                  CMD_RETURN: begin
                     wsp   <= fp_val;
                     rf_we <= 1'b1; rf_waddr <= SPR; rf_wdata <= fp_val;
                     state <= ST_RET_FP;
                  end
                  CMD_PUSH: begin
                     rf_we <= 1'b1; rf_waddr <= opa_idx; rf_wdata <= dn1[0];
                     state <= ST_PUSH_W;
                  end
                  default: begin
                     wsp   <= opa_val;
                     state <= ST_POP_R;
                  end
               endcase
            end
            ST_CALL_RA: if (mem_ack) begin
               wsp   <= dn1[1];
               rf_we <= 1'b1; rf_waddr <= SPR; rf_wdata <= dn1[1];
               state <= ST_CALL_FP;
            end
            ST_CALL_FP: if (mem_ack) begin
               rf_we <= 1'b1; rf_waddr <= FPR; rf_wdata <= wsp;
               if (use_new_sp) tgt <= wsp;
               pc_pend <= 1'b1;
               state   <= ST_FIN;
            end
            ST_RET_FP: if (mem_ack) begin
               rf_we <= 1'b1; rf_waddr <= FPR; rf_wdata <= mem_rdata;
               state <= ST_RET_SP;
            end
            ST_RET_SP: begin
               wsp   <= up1[1];
               rf_we <= 1'b1; rf_waddr <= SPR; rf_wdata <= up1[1];
               state <= ST_RET_PC;
            end
            ST_RET_PC: if (mem_ack) begin
               tgt     <= mem_rdata;
               rf_we   <= 1'b1; rf_waddr <= SPR; rf_wdata <= up2[1];
               pc_pend <= 1'b1;
               state   <= ST_FIN;
            end
            ST_PUSH_W: if (mem_ack) state <= ST_FIN;
            ST_POP_R: if (mem_ack) begin
               rf_we <= 1'b1; rf_waddr <= b_q; rf_wdata <= mem_rdata;
               if (a_q == b_q) wsp <= mem_rdata;
               state <= ST_POP_INC;
            end
            ST_POP_INC: begin
               rf_we <= 1'b1; rf_waddr <= a_q; rf_wdata <= up1[1];
               state <= ST_FIN;
            end
            default: begin
               done     <= 1'b1;
               busy     <= 1'b0;
               pc_we    <= pc_pend;
               pc_wdata <= tgt;
               pc_pend  <= 1'b0;
               state    <= ST_IDLE;
            end
         endcase
      end
   end

   // R9: done lasts one cycle, with busy and the memory port idle
   a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   a_r9_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy && !mem_req);
   // R9: the PC is only written as a command finishes
   a_r9_pc_in_done: assert property (@(posedge clk) disable iff (!rst_n)
      pc_we |-> done);
   // R7: no advance past a transfer without its acknowledge
   a_r7_wait_ack: assert property (@(posedge clk) disable iff (!rst_n)
      waiting && !mem_ack |=> $stable(state) && !done);
   // R8: memory traffic only while a command is in progress
   a_r8_req_busy: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> busy);
endmodule

// File: tb/tb_frame_seq.sv
`timescale 1ns/1ps
module tb_frame_seq;
   localparam int DW = 32;
   localparam int RW = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;   // 50 MHz

   logic          cmd_valid;
   logic [2:0]    cmd_op;
   logic [DW-1:0] cmd_pc, cmd_tgt, fp_val, sp_val, opa_val, opb_val;
   logic [RW-1:0] opa_idx, opb_idx;
   logic          busy, done, mem_req, mem_we, mem_ack, rf_we, pc_we;
   logic [DW-1:0] mem_addr, mem_wdata, mem_rdata, rf_wdata, pc_wdata;
   logic [RW-1:0] rf_waddr;

   frame_seq #(.DW(DW), .RW(RW)) dut (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_pc(cmd_pc),
      .cmd_tgt(cmd_tgt), .fp_val(fp_val), .sp_val(sp_val), .opa_idx(opa_idx),
      .opb_idx(opb_idx), .opa_val(opa_val), .opb_val(opb_val), .busy(busy), .done(done),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_ack(mem_ack), .mem_rdata(mem_rdata), .rf_we(rf_we), .rf_waddr(rf_waddr),
      .rf_wdata(rf_wdata), .pc_we(pc_we), .pc_wdata(pc_wdata));

   // environment: register file, PC, word memory
   logic [31:0] regs [16];
   logic [31:0] pc_q;
   logic [31:0] mem [2048];
   logic [31:0] wlog_addr [8];
   logic [31:0] wlog_data [8];
   int wr_total = 0, rf_cnt = 0, done_cnt = 0, lat = 0, wcnt = 0, cyc = 0;
   int checks = 0, fails = 0;
   bit finished = 0;

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 16; i++) regs[i] <= 32'h0;
         regs[0] <= 32'h1000; regs[1] <= 32'h2000; regs[2] <= 32'h11;
         regs[4] <= 32'h3000; regs[5] <= 32'h800;
         pc_q <= 32'h0;
      end else begin
         if (rf_we) begin regs[rf_waddr] <= rf_wdata; rf_cnt <= rf_cnt + 1; end
         if (pc_we) pc_q <= pc_wdata;
         if (done) done_cnt <= done_cnt + 1;
      end
   end

   always @(posedge clk) begin
      if (!rst_n) begin
         mem_ack <= 1'b0; mem_rdata <= 32'h0; wcnt <= 0;
      end else if (mem_ack) begin
         mem_ack <= 1'b0; wcnt <= 0;
      end else if (mem_req) begin
         if (wcnt >= lat) begin
            mem_ack <= 1'b1;
            if (mem_we) begin
               mem[mem_addr[12:2]] <= mem_wdata;
               wlog_addr[wr_total % 8] <= mem_addr;
               wlog_data[wr_total % 8] <= mem_wdata;
               wr_total <= wr_total + 1;
            end else begin
               mem_rdata <= mem[mem_addr[12:2]];
            end
         end else begin
            wcnt <= wcnt + 1;
         end
      end
   end

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic drive(input logic [2:0] op, input logic [3:0] a, input logic [3:0] b,
                        input logic [31:0] pc, input logic [31:0] tgt);
      cmd_valid = 1'b1; cmd_op = op; cmd_pc = pc; cmd_tgt = tgt;
      opa_idx = a; opb_idx = b;
      fp_val = regs[0]; sp_val = regs[1]; opa_val = regs[a]; opb_val = regs[b];
      @(negedge clk);
      cmd_valid = 1'b0;
   endtask

   task automatic wait_done(input int start, input string tag);
      int n = 0;
      while (done_cnt == start && n < 200) begin @(negedge clk); n++; end
      if (n >= 200) check({tag, " timeout"}, 32'd0, 32'd1);
      repeat (2) @(negedge clk);
   endtask

   typedef struct packed {
      logic [2:0]  op;
      logic [3:0]  a;
      logic [3:0]  b;
      logic [31:0] pc;
      logic [31:0] tgt;
      logic [31:0] efp;
      logic [31:0] esp;
      logic [31:0] epc;
      logic [3:0]  cidx;
      logic [31:0] cval;
      logic [31:0] maddr;
      logic [31:0] mval;
   } vec_t;

   localparam vec_t TBL [10] = '{
      // R1 R2 absolute call
      '{3'd0, 4'd0, 4'd0, 32'h100, 32'h500, 32'h1FF4, 32'h1FF4, 32'h500, 4'd0, 32'h1FF4, 32'h1FF8, 32'h106},
      // R5 push
      '{3'd3, 4'd1, 4'd2, 32'h0, 32'h0, 32'h1FF4, 32'h1FF0, 32'h500, 4'd2, 32'h11, 32'h1FF0, 32'h11},
      // R6 pop
      '{3'd4, 4'd1, 4'd3, 32'h0, 32'h0, 32'h1FF4, 32'h1FF4, 32'h500, 4'd3, 32'h11, 32'h1FF4, 32'h1000},
      // R2 R3 register call
      '{3'd1, 4'd5, 4'd0, 32'h520, 32'h0, 32'h1FE8, 32'h1FE8, 32'h800, 4'd5, 32'h800, 32'h1FEC, 32'h522},
      // R4 inner return
      '{3'd2, 4'd0, 4'd0, 32'h0, 32'h0, 32'h1FF4, 32'h1FF4, 32'h522, 4'd3, 32'h11, 32'h1FE8, 32'h1FF4},
      // R4 outer return
      '{3'd2, 4'd0, 4'd0, 32'h0, 32'h0, 32'h1000, 32'h2000, 32'h106, 4'd2, 32'h11, 32'h1FF8, 32'h106},
      // R5 push with equal indices
      '{3'd3, 4'd4, 4'd4, 32'h0, 32'h0, 32'h1000, 32'h2000, 32'h106, 4'd4, 32'h2FFC, 32'h2FFC, 32'h2FFC},
      // R6 pop with equal indices
      '{3'd4, 4'd4, 4'd4, 32'h0, 32'h0, 32'h1000, 32'h2000, 32'h106, 4'd4, 32'h3000, 32'h2FFC, 32'h2FFC},
      // R3 register call through the stack pointer
      '{3'd1, 4'd1, 4'd0, 32'h600, 32'h0, 32'h1FF4, 32'h1FF4, 32'h1FF4, 4'd0, 32'h1FF4, 32'h1FF8, 32'h602},
      // R4 return
      '{3'd2, 4'd0, 4'd0, 32'h0, 32'h0, 32'h1000, 32'h2000, 32'h602, 4'd3, 32'h11, 32'h1FF4, 32'h1000}
   };

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc == 100000 && !finished) begin
         fails++;
         checks++;
         $display("FAIL watchdog actual %0d expected done", cyc);
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      int start, rf0, bsy, wr0;
      cmd_valid = 0; cmd_op = 0; cmd_pc = 0; cmd_tgt = 0; fp_val = 0; sp_val = 0;
      opa_val = 0; opb_val = 0; opa_idx = 0; opb_idx = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R10 reset state
      check("R10 busy", {31'd0, busy}, 32'd0);
      check("R10 done", {31'd0, done}, 32'd0);
      check("R10 mem_req", {31'd0, mem_req}, 32'd0);
      check("R10 rf_we", {31'd0, rf_we}, 32'd0);
      check("R10 pc_we", {31'd0, pc_we}, 32'd0);

      for (int i = 0; i < 10; i++) begin
         lat = i % 3;
         start = done_cnt;
         drive(TBL[i].op, TBL[i].a, TBL[i].b, TBL[i].pc, TBL[i].tgt);
         wait_done(start, "R9 table");
         check($sformatf("R1/R4 vec%0d fp", i), regs[0], TBL[i].efp);
         check($sformatf("R1/R4 vec%0d sp", i), regs[1], TBL[i].esp);
         check($sformatf("R2/R3 vec%0d pc", i), pc_q, TBL[i].epc);
         check($sformatf("R5/R6 vec%0d reg", i), regs[TBL[i].cidx], TBL[i].cval);
         check($sformatf("R7 vec%0d mem", i), mem[TBL[i].maddr[12:2]], TBL[i].mval);
         check($sformatf("R9 vec%0d done count", i), done_cnt - start, 32'd1);
      end

      // R8: command during busy is ignored
      lat = 2;
      start = done_cnt;
      drive(3'd3, 4'd1, 4'd3, 32'h0, 32'h0);
      check("R8 busy after accept", {31'd0, busy}, 32'd1);
      @(negedge clk);
      drive(3'd4, 4'd1, 4'd5, 32'h0, 32'h0);
      wait_done(start, "R8");
      repeat (6) @(negedge clk);
      check("R8 sp after ignored pop", regs[1], 32'h1FFC);
      check("R8 reg5 untouched", regs[5], 32'h800);
      check("R8 single done", done_cnt - start, 32'd1);

      // R8: unknown command code ignored
      rf0 = rf_cnt; start = done_cnt; bsy = 0;
      drive(3'd7, 4'd1, 4'd2, 32'h0, 32'h0);
      for (int k = 0; k < 6; k++) begin
         if (busy) bsy++;
         @(negedge clk);
      end
      check("R8 unknown no busy", bsy, 32'd0);
      check("R8 unknown no writes", rf_cnt - rf0, 32'd0);
      check("R8 unknown no done", done_cnt - start, 32'd0);

      // R1 R7 store order of a call
      lat = 1;
      wr0 = wr_total; start = done_cnt;
      drive(3'd0, 4'd0, 4'd0, 32'h700, 32'h900);
      wait_done(start, "R1 order");
      check("R1 first store addr", wlog_addr[wr0 % 8], 32'h1FF4);
      check("R2 first store data", wlog_data[wr0 % 8], 32'h706);
      check("R1 second store addr", wlog_addr[(wr0 + 1) % 8], 32'h1FF0);
      check("R1 second store data", wlog_data[(wr0 + 1) % 8], 32'h1000);
      check("R1 store count", wr_total - wr0, 32'd2);
      check("R1 pc", pc_q, 32'h900);
      check("R9 idle after done", {31'd0, busy}, 32'd0);

      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule